// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial stereo stream into parallel samples. The stream has a bit clock, a frame clock that marks the left and right halves of each frame, and one data line. A 2-bit format code chooses one of four framings at run time. Two of them are MSB-first framings that start at a fixed slot after the frame-clock edge. The other two are right-aligned framings that end on the last slot of each half. One select bit chooses which of two bit-clock/frame-clock pairs feeds the receiver. A second select bit routes one of two master clocks to an output.

Both clock pairs are treated as data that run synchronously with the system clock. The block registers the chosen pair and the data line once, and detects bit-clock rising edges by comparing against the previous sample. Each rising edge takes one data bit. A change of frame-clock level between consecutive rising edges marks the start of a new half-frame. When a right-channel half completes, the block presents both 24-bit samples together with a one-cycle strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and on leaving it, `left_out` and `right_out` are zero and `sample_valid` is low.
- R2: Format 00 (left-justified): the sample is the first 24 bit slots of a half, MSB first in slot 0. When a half has fewer than 24 slots the missing low bits are zero. Slots after slot 23 are ignored.
- R3: Format 01 (I2S): the MSB is in slot 1, the slot after the frame-clock change. Slots 1..24 form the sample, MSB first. Slot 0 and slots after 24 are ignored. Halves shorter than 25 slots are zero-padded at the LSB end. The frame clock is low for the left channel.
- R4: Format 10: the last 16 slots of a half carry a 16-bit sample with its LSB in the last slot. It is sign-extended to 24 bits and earlier slots are ignored.
- R5: Format 11: the last 24 slots of a half carry the 24-bit sample with its LSB in the last slot. Earlier slots are ignored.
- R6: In formats 00, 10 and 11 the frame clock is high for the left channel. A half whose level marks left goes to `left_out`, and the other half goes to `right_out`.
- R7: `sample_valid` pulses for one cycle once per frame, when a right half that follows a left half completes. Both outputs update in that cycle and hold their values otherwise.
- R8: The right half of a frame completes at the first bit-clock rising edge whose frame-clock level differs from the previous one. `sample_valid` and the new data are visible 2 system-clock cycles after that rising edge appears at the inputs.
- R9: `port_sel` = 0 takes the bit and frame clocks from `bclk_a`/`lrck_a`, and 1 takes them from `bclk_b`/`lrck_b`. The unselected pair has no effect.
- R10: `mclk_out` equals `mclk_a` when `mclk_sel` = 0 and equals `mclk_b` when it is 1.
- R11: After reset, the half that runs before the first frame-clock change is discarded. No strobe is given until a complete left half and then a complete right half have been received. Halves hold at most 32 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Frame format code (00 LJ, 01 I2S, 10 RJ16, 11 RJ24) |
| port_sel | input | 1 | Clock pair select (0 = pair a, 1 = pair b) |
| bclk_a | input | 1 | Bit clock, pair a |
| lrck_a | input | 1 | Frame clock, pair a |
| bclk_b | input | 1 | Bit clock, pair b |
| lrck_b | input | 1 | Frame clock, pair b |
| sdata | input | 1 | Serial audio data |
| mclk_sel | input | 1 | Master clock select |
| mclk_a | input | 1 | Master clock candidate 0 |
| mclk_b | input | 1 | Master clock candidate 1 |
| mclk_out | output | 1 | Selected master clock |
| left_out | output | 24 | Left sample |
| right_out | output | 24 | Right sample |
| sample_valid | output | 1 | One-cycle strobe per completed frame |

## Verification
The bench drives the inputs on falling system-clock edges. It records the cycle in which it raises the bit clock for the first slot of each new half. The frame result is due 2 cycles later: one cycle for the input register and one for the output register. On every strobe the bench checks that exact distance against the recorded cycle, as well as the data values. The master-clock mux has no register, so it is checked in the same half-cycle in which its inputs change. Frame counts are compared at the end of each run so that missing or extra strobes are caught.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int SLOT_MAX = 32;
  localparam int SHORT_W  = 16;
  localparam int CNT_W    = $clog2(SLOT_MAX + 1);
  localparam int EXT_W    = SLOT_MAX + SAMPLE_W;

  typedef enum logic [1:0] {
    FMT_LJ   = 2'b00,
    FMT_I2S  = 2'b01,
    FMT_RJ16 = 2'b10,
    FMT_RJ24 = 2'b11
  } fmt_e;

  // frame-clock level that marks the left half
  function automatic logic left_level(fmt_e f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

  // sh holds the half's bits with the newest at bit 0; n is the number of slots seen
  function automatic logic [SAMPLE_W-1:0] pick_word(fmt_e f,
                                                    logic [SLOT_MAX-1:0] sh,
                                                    logic [CNT_W-1:0] n);
    logic [EXT_W-1:0] ext;
    logic [CNT_W:0]   amt;
    logic [SAMPLE_W-1:0] w;
    ext = '0;
    amt = '0;
    case (f)
      FMT_RJ24: w = sh[SAMPLE_W-1:0];
      FMT_RJ16: w = {{(SAMPLE_W-SHORT_W){sh[SHORT_W-1]}}, sh[SHORT_W-1:0]};
      default: begin
        // move the first data slot to the top of the extended word
        amt = (CNT_W+1)'(SLOT_MAX) - (CNT_W+1)'(n)
              + ((f == FMT_I2S) ? (CNT_W+1)'(1) : (CNT_W+1)'(0));
        ext = {sh, {SAMPLE_W{1'b0}}} << amt;
        w   = ext[EXT_W-1 -: SAMPLE_W];
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sarx_port_pick.sv
module sarx_port_pick #(
  parameter int NPORT = 2,
  localparam int SELW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] bclk_in,
  input  logic [NPORT-1:0] lrck_in,
  input  logic [SELW-1:0]  sel,
  input  logic             sd_in,
  output logic             bclk_q,
  output logic             lrck_q,
  output logic             sd_q
);

  logic bclk_m, lrck_m;

  always_comb begin
    bclk_m = bclk_in[sel];
    lrck_m = lrck_in[sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_m;
      lrck_q <= lrck_m;
      sd_q   <= sd_in;
    end
  end

endmodule

// File: rtl/sarx_edge_find.sv
module sarx_edge_find #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev[i] <= 1'b0;
      else        prev[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~prev[i];
  end

endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
  import sarx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  fmt_e                fmt,
  input  logic                bit_rise,
  input  logic                lr_in,
  input  logic                sd_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                sample_valid
);

  logic [SLOT_MAX-1:0] shreg;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] left_hold;
  logic                lr_last, primed, synced, have_left;

  // named internal events
  logic                lr_change;
  logic                half_left;
  logic [SAMPLE_W-1:0] word;

  assign lr_change = primed && (lr_in != lr_last);
  assign half_left = (lr_last == left_level(fmt));
  assign word      = pick_word(fmt, shreg, cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg        <= '0;
      cnt          <= '0;
      left_hold    <= '0;
      left_out     <= '0;
      right_out    <= '0;
      sample_valid <= 1'b0;
      lr_last      <= 1'b0;
      primed       <= 1'b0;
      synced       <= 1'b0;
      have_left    <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (bit_rise) begin
        primed  <= 1'b1;
        lr_last <= lr_in;
        shreg   <= {shreg[SLOT_MAX-2:0], sd_in};
        if (lr_change) begin
          cnt    <= CNT_W'(1);
          synced <= 1'b1;
          if (synced) begin
            if (half_left) begin
              left_hold <= word;
              have_left <= 1'b1;
            end else if (have_left) begin
              left_out     <= left_hold;
              right_out    <= word;
              sample_valid <= 1'b1;
              have_left    <= 1'b0;
            end
          end
        end else if (cnt != CNT_W'(SLOT_MAX)) begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SLOT_MAX));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(left_out) && $stable(right_out)));

  assert_valid_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(bit_rise && lr_change));

  assert_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && ($past(fmt) == FMT_RJ16)) |->
      (right_out[SAMPLE_W-1:SHORT_W] == {(SAMPLE_W-SHORT_W){right_out[SHORT_W-1]}}));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt,
  input  logic                port_sel,
  input  logic                bclk_a,
  input  logic                lrck_a,
  input  logic                bclk_b,
  input  logic                lrck_b,
  input  logic                sdata,
  input  logic                mclk_sel,
  input  logic                mclk_a,
  input  logic                mclk_b,
  output logic                mclk_out,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                sample_valid
);

  logic bclk_q, lrck_q, sd_q;
  logic bit_rise;

  assign mclk_out = mclk_sel ? mclk_b : mclk_a;

  sarx_port_pick #(.NPORT(2)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk_in ({bclk_b, bclk_a}),
    .lrck_in ({lrck_b, lrck_a}),
    .sel     (port_sel),
    .sd_in   (sdata),
    .bclk_q  (bclk_q),
    .lrck_q  (lrck_q),
    .sd_q    (sd_q)
  );

  sarx_edge_find #(.W(1)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (bclk_q),
    .rise  (bit_rise)
  );

  sarx_deser u_deser (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt          (fmt_e'(fmt)),
    .bit_rise     (bit_rise),
    .lr_in        (lrck_q),
    .sd_in        (sd_q),
    .left_out     (left_out),
    .right_out    (right_out),
    .sample_valid (sample_valid)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!sample_valid && (left_out == '0) && (right_out == '0)));

endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic port_sel = 1'b0;
  logic bclk_sig = 1'b0, lrck_sig = 1'b0, sd = 1'b0;
  logic mclk_sel = 1'b0, mclk_a = 1'b0, mclk_b = 1'b0;
  logic mclk_out, sample_valid;
  logic [23:0] left_out, right_out;

  wire bclk_a = port_sel ? 1'b0 : bclk_sig;
  wire lrck_a = port_sel ? 1'b0 : lrck_sig;
  wire bclk_b = port_sel ? bclk_sig : 1'b0;
  wire lrck_b = port_sel ? lrck_sig : 1'b0;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .port_sel(port_sel),
    .bclk_a(bclk_a), .lrck_a(lrck_a), .bclk_b(bclk_b), .lrck_b(lrck_b),
    .sdata(sd), .mclk_sel(mclk_sel), .mclk_a(mclk_a), .mclk_b(mclk_b),
    .mclk_out(mclk_out), .left_out(left_out), .right_out(right_out),
    .sample_valid(sample_valid)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0, t_mark = 0, nvalid = 0, wr = 0, rd = 0;
  logic [23:0] exq_l [0:255];
  logic [23:0] exq_r [0:255];
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string fmt_tag(logic [1:0] f);
    case (f)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // expected 24-bit result for a word w sent in a half of 'slots' slots
  function automatic logic [23:0] exp_word(logic [1:0] f, int slots, logic [23:0] w);
    logic [23:0] m;
    case (f)
      2'b00: begin
        m = (slots >= 24) ? 24'hFFFFFF : ~((24'h1 << (24 - slots)) - 24'h1);
        return w & m;
      end
      2'b01: begin
        m = (slots >= 25) ? 24'hFFFFFF : ~((24'h1 << (25 - slots)) - 24'h1);
        return w & m;
      end
      2'b10: return {{8{w[15]}}, w[15:0]};
      default: return w;
    endcase
  endfunction

  // line value in slot s; unused slots carry 1 so an ignored slot would show
  function automatic logic bit_of(logic [1:0] f, int slots, logic [23:0] w, int s);
    int k;
    k = slots - 1 - s;
    case (f)
      2'b00: return (s < 24) ? w[23 - s] : 1'b1;
      2'b01: return (s >= 1 && s <= 24) ? w[24 - s] : 1'b1;
      2'b10: return (k < 16) ? w[k] : 1'b1;
      default: return (k < 24) ? w[k] : 1'b1;
    endcase
  endfunction

  function automatic logic [23:0] pat(int k);
    case (k % 8)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'h000000;
      3: return 24'hFFFFFF;
      default: return 24'((k * 32'h9E3779B1) ^ (k << 7) ^ 32'h5A1C3);
    endcase
  endfunction

  // R8: result due two cycles after the rise that opens a new half
  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      nvalid++;
      chk(cyc - t_mark == 2, "R8", "latency", 32'(cyc - t_mark), 32'd2);
      if (rd < wr) begin
        chk(left_out == exq_l[rd], fmt_tag(fmt), "R6 left", {8'h0, left_out}, {8'h0, exq_l[rd]});
        chk(right_out == exq_r[rd], fmt_tag(fmt), "R6 right", {8'h0, right_out}, {8'h0, exq_r[rd]});
      end else begin
        chk(1'b0, "R7", "unexpected strobe", 32'(rd), 32'(wr));
      end
      rd++;
    end
  end

  task automatic drive_bit(logic lv, logic b, bit mark);
    bclk_sig = 1'b0; lrck_sig = lv; sd = b;
    repeat (4) @(negedge clk);
    bclk_sig = 1'b1;
    if (mark) t_mark = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_half(logic lv, logic [1:0] f, int slots, logic [23:0] w);
    for (int s = 0; s < slots; s++) drive_bit(lv, bit_of(f, slots, w, s), s == 0);
  endtask

  task automatic start_cfg(logic [1:0] f, logic ps);
    rst_n = 1'b0; fmt = f; port_sel = ps; bclk_sig = 1'b0; lrck_sig = 1'b0; sd = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sample_valid && left_out == 0 && right_out == 0, "R1", "reset state",
        {7'h0, sample_valid, left_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  int pidx = 0;

  task automatic run_cfg(logic [1:0] f, int slots, logic ps, int nfr);
    logic lv;
    int n0;
    logic [23:0] wl, wr_w;
    start_cfg(f, ps);
    lv = (f == 2'b01) ? 1'b0 : 1'b1;
    rd = 0; wr = 0; n0 = nvalid;
    for (int i = 0; i < 3; i++) drive_bit(~lv, 1'b1, 1'b0); // partial half, discarded (R11)
    for (int fr = 0; fr < nfr; fr++) begin
      wl = pat(pidx); wr_w = pat(pidx + 1); pidx += 2;
      exq_l[wr] = exp_word(f, slots, wl);
      exq_r[wr] = exp_word(f, slots, wr_w);
      wr++;
      drive_half(lv, f, slots, wl);
      drive_half(~lv, f, slots, wr_w);
    end
    drive_bit(lv, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    chk(nvalid - n0 == nfr, "R7 R9 R11", "frame count", 32'(nvalid - n0), 32'(nfr));
  endtask

  initial begin
    int n0;
    @(negedge clk);
    // R10: master clock routing
    mclk_a = 1'b1; mclk_b = 1'b0; mclk_sel = 1'b0; #1;
    chk(mclk_out == 1'b1, "R10", "sel0 a=1", 32'(mclk_out), 32'd1);
    mclk_sel = 1'b1; #1;
    chk(mclk_out == 1'b0, "R10", "sel1 b=0", 32'(mclk_out), 32'd0);
    mclk_a = 1'b0; mclk_b = 1'b1; #1;
    chk(mclk_out == 1'b1, "R10", "sel1 b=1", 32'(mclk_out), 32'd1);
    mclk_sel = 1'b0; #1;
    chk(mclk_out == 1'b0, "R10", "sel0 a=0", 32'(mclk_out), 32'd0);
    @(negedge clk);

    // R11: a left half alone gives no strobe
    start_cfg(2'b00, 1'b0);
    n0 = nvalid;
    for (int i = 0; i < 5; i++) drive_bit(1'b0, 1'b1, 1'b0);
    drive_half(1'b1, 2'b00, 24, 24'h123456);
    drive_bit(1'b0, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    chk(nvalid == n0, "R11", "no strobe without right half", 32'(nvalid - n0), 32'd0);

    // sweep: formats x half lengths x clock pairs
    for (int f = 0; f < 4; f++) begin
      for (int si = 0; si < 3; si++) begin
        for (int ps = 0; ps < 2; ps++) begin
          int slots;
          slots = (si == 0) ? 16 : (si == 1) ? 24 : 32;
          if (f == 3 && slots < 24) slots = 25;
          run_cfg(2'(f), slots, ps[0], 3);
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R7 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule